// File: doc/BRIEF.md
# Framed 12-bit Word Serializer

This block turns 12-bit parallel words into a one-bit-per-clock serial stream. The clock of the block is the serial bit clock: every cycle out of reset emits exactly one serial slot on `ser_out`, and `bit_clk_en` tells the downstream clock forwarder that a slot is valid in that cycle. Data and forwarded clock therefore change on the same edge.

A word is offered on `word_in` and taken on the rising edge of `word_strobe`, which is sampled synchronously. The output is divided into frames. A frame carries the pending word with the least significant bit first, followed by a two-slot boundary marker. When no word is pending as a frame begins, the frame goes out as all zeros, marker included. Words can therefore arrive at any rate up to one per frame.

`overclock` selects the frame cadence. In standard cadence every frame is 14 slots long. In overclocked cadence the frame lengths repeat as 14, 14, 16, and the two extra slots of the long frame are always zero. If a second strobe edge arrives before the pending word has gone out, the newer word replaces it and a sticky `overrun` flag is raised.

Top module: `sfc_serializer`

## Requirements
- R1: While `rst_n` is low at a clock edge, `ser_out`, `bit_clk_en` and `overrun` are 0 after that edge, and the cadence restarts with a 14-slot frame.
- R2: With `overclock` = 0, every frame is 14 slots long.
- R3: With `overclock` = 1, frame lengths repeat 14, 14, 16 counting from the first frame after reset, which is frame 0, so frame n is long when n mod 3 = 2.
- R4: A frame that carries a word emits `word_in[0]` first through `word_in[11]` in slots 0 to 11, then a 1 in slot 12 and a 0 in slot 13.
- R5: Slots 14 and 15 of a 16-slot frame are always 0.
- R6: A word is captured only on a rising edge of `word_strobe`. A strobe held high for longer than a frame yields one framed word, and the following frame is idle.
- R7: A frame that begins with no pending word emits 0 in every slot.
- R8: A second strobe edge before the pending word is sent replaces that word, so the frame carries the newer word, and it sets `overrun`, which stays 1 until reset.
- R9: `bit_clk_en` is 1 in every cycle after the first clock edge with `rst_n` high. Slot 0 of frame 0 appears on `ser_out` after that first edge, and each later edge advances one slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock; one slot per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| overclock | input | 1 | 0 = standard 14-slot cadence, 1 = 14/14/16 cadence |
| word_strobe | input | 1 | Word strobe; a rising edge captures `word_in` |
| word_in | input | 12 | Parallel word, bit 0 sent first |
| ser_out | output | 1 | Serial data, registered |
| bit_clk_en | output | 1 | Forwarded bit-clock enable, aligned with `ser_out` |
| overrun | output | 1 | Sticky flag: a pending word was overwritten |

## Verification
A slot counter that is off by one shifts the boundary marker: the 1 then lands in the wrong slot, and every later frame shows up misaligned when its first bit is compared. Because of this, a wrong cadence count surfaces as a mismatch in the first frame whose length is wrong, which is at most three frames after the fault. A pending flag that is not cleared shows up as a repeated word in a frame the bench expects to be idle. A mishandled strobe edge shows up as an extra or missing word within one frame of the strobe. Each frame is compared whole, with the expected frame built from the cadence index and the planned words.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
   typedef enum logic {
      CAD_STD = 1'b0,
      CAD_OVC = 1'b1
   } cadence_e;

   function automatic int unsigned frame_slots(int unsigned data_w, int unsigned mark_w,
                                               int unsigned pad_w, bit long_frame);
      return data_w + mark_w + (long_frame ? pad_w : 0);
   endfunction
endpackage

// File: rtl/sfc_capture.sv
module sfc_capture #(
   parameter int unsigned DATA_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strobe,
   input  logic [DATA_W-1:0] word_in,
   input  logic              take,
   output logic [DATA_W-1:0] pend_word,
   output logic              pend_valid,
   output logic              overrun
);
   logic strobe_q;
   logic rise;

   assign rise = strobe & ~strobe_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         strobe_q   <= 1'b0;
         pend_word  <= '0;
         pend_valid <= 1'b0;
         overrun    <= 1'b0;
      end else begin
         strobe_q   <= strobe;
         pend_valid <= rise | (pend_valid & ~take);
         overrun    <= overrun | (rise & pend_valid & ~take);
         if (rise) pend_word <= word_in;
      end
   end

   // R8: once set, the overrun flag never clears outside reset
   a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> overrun);

   // R6: a strobe that stays high creates no new pending word
   a_r6_level_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && strobe_q && !pend_valid) |=> !pend_valid);
endmodule

// File: rtl/sfc_cadence_timer.sv
module sfc_cadence_timer #(
   parameter int unsigned SHORT_LEN  = 14,
   parameter int unsigned LONG_LEN   = 16,
   parameter int unsigned CAD_PERIOD = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ovc,
   output logic frame_start
);
   localparam int unsigned SW = (LONG_LEN > 2) ? $clog2(LONG_LEN) : 1;
   localparam int unsigned CW = (CAD_PERIOD > 1) ? $clog2(CAD_PERIOD) : 1;

   logic [SW-1:0] slot_q;
   logic [SW-1:0] last_q;
   logic          long_next;

   assign frame_start = (slot_q == '0);

   generate
      if (CAD_PERIOD > 1) begin : g_cad
         logic [CW-1:0] cad_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               cad_q <= '0;
            else if (frame_start)
               cad_q <= (!ovc || cad_q == CW'(CAD_PERIOD-1)) ? '0 : cad_q + 1'b1;
         end
         assign long_next = ovc && (cad_q == CW'(CAD_PERIOD-1));

         // R3: the cadence index stays inside its period
         a_r3_cad_range: assert property (@(posedge clk) disable iff (!rst_n)
            cad_q <= CW'(CAD_PERIOD-1));

         // R2: standard cadence never schedules a long frame
         a_r2_std_short: assert property (@(posedge clk) disable iff (!rst_n)
            (frame_start && !ovc) |=> (last_q == SW'(SHORT_LEN-1)));
      end else begin : g_flat
         assign long_next = ovc;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot_q <= '0;
         last_q <= SW'(SHORT_LEN-1);
      end else begin
         if (frame_start)
            last_q <= long_next ? SW'(LONG_LEN-1) : SW'(SHORT_LEN-1);
         slot_q <= (slot_q == last_q) ? '0 : slot_q + 1'b1;
      end
   end

   // R2/R3: the slot index never runs past the end of the current frame
   a_r3_slot_bound: assert property (@(posedge clk) disable iff (!rst_n)
      slot_q <= last_q);
endmodule

// File: rtl/sfc_shifter.sv
module sfc_shifter #(
   parameter int unsigned DATA_W = 12,
   parameter int unsigned MARK_W = 2,
   parameter int unsigned FW     = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              load_valid,
   input  logic [DATA_W-1:0] load_word,
   output logic              ser_out,
   output logic              bit_clk_en
);
   logic [FW-1:0] frame;
   logic [FW-1:0] sh_q;

   always_comb begin
      frame = '0;
      if (load_valid) begin
         frame[DATA_W-1:0]         = load_word;
         frame[DATA_W +: MARK_W]   = MARK_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q       <= '0;
         ser_out    <= 1'b0;
         bit_clk_en <= 1'b0;
      end else begin
         bit_clk_en <= 1'b1;
         if (load) begin
            ser_out <= frame[0];
            sh_q    <= frame >> 1;
         end else begin
            ser_out <= sh_q[0];
            sh_q    <= sh_q >> 1;
         end
      end
   end

   // R9: the forwarded clock enable is up in every cycle after reset ends
   a_r9_clk_en_live: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> bit_clk_en);

   // R7: an idle frame starts with a zero slot
   a_r7_idle_first_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !load_valid) |=> !ser_out);
endmodule

// File: rtl/sfc_serializer.sv
module sfc_serializer #(
   parameter int unsigned DATA_W     = 12,
   parameter int unsigned MARK_W     = 2,
   parameter int unsigned PAD_W      = 2,
   parameter int unsigned CAD_PERIOD = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              overclock,
   input  logic              word_strobe,
   input  logic [DATA_W-1:0] word_in,
   output logic              ser_out,
   output logic              bit_clk_en,
   output logic              overrun
);
   import sfc_pkg::*;

   localparam int unsigned SHORT_LEN = frame_slots(DATA_W, MARK_W, PAD_W, 1'b0);
   localparam int unsigned LONG_LEN  = frame_slots(DATA_W, MARK_W, PAD_W, 1'b1);

   initial begin
      if (DATA_W < 1)     $fatal(1, "DATA_W must be at least 1");
      if (MARK_W < 2)     $fatal(1, "MARK_W must be at least 2");
      if (CAD_PERIOD < 1) $fatal(1, "CAD_PERIOD must be at least 1");
   end

   cadence_e          mode;
   logic              frame_start;
   logic [DATA_W-1:0] pend_word;
   logic              pend_valid;

   assign mode = cadence_e'(overclock);

   sfc_cadence_timer #(
      .SHORT_LEN (SHORT_LEN),
      .LONG_LEN  (LONG_LEN),
      .CAD_PERIOD(CAD_PERIOD)
   ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .ovc        (mode == CAD_OVC),
      .frame_start(frame_start)
   );

   sfc_capture #(.DATA_W(DATA_W)) u_capture (
      .clk       (clk),
      .rst_n     (rst_n),
      .strobe    (word_strobe),
      .word_in   (word_in),
      .take      (frame_start),
      .pend_word (pend_word),
      .pend_valid(pend_valid),
      .overrun   (overrun)
   );

   sfc_shifter #(
      .DATA_W(DATA_W),
      .MARK_W(MARK_W),
      .FW    (LONG_LEN)
   ) u_shifter (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (frame_start),
      .load_valid(pend_valid),
      .load_word (pend_word),
      .ser_out   (ser_out),
      .bit_clk_en(bit_clk_en)
   );
endmodule

// File: tb/sfc_serializer_test.sv
module sfc_serializer_test;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        overclock;
   logic        word_strobe;
   logic [11:0] word_in;
   logic        ser_out;
   logic        bit_clk_en;
   logic        overrun;

   int checks = 0;
   int fails  = 0;

   localparam int NF = 10;

   logic [11:0] pw [0:15];
   bit          pv [0:15];
   bit          pd [0:15];
   bit          ph [0:15];

   always #5 clk = ~clk;

   sfc_serializer uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .overclock  (overclock),
      .word_strobe(word_strobe),
      .word_in    (word_in),
      .ser_out    (ser_out),
      .bit_clk_en (bit_clk_en),
      .overrun    (overrun)
   );

   task automatic check(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic clear_plan();
      for (int i = 0; i < 16; i++) begin
         pw[i] = '0; pv[i] = 0; pd[i] = 0; ph[i] = 0;
      end
   endtask

   task automatic run_phase(bit ovc_mode);
      int          pos, fidx, len, hold_cnt;
      bit          exp_ovr, en_bad;
      logic [15:0] got, exp;
      string       tag;
      rst_n       = 1'b0;
      word_strobe = 1'b0;
      word_in     = '0;
      overclock   = ovc_mode;
      repeat (3) @(negedge clk);
      // R1: reset state
      check(ser_out == 1'b0 && bit_clk_en == 1'b0 && overrun == 1'b0, "R1 reset outputs",
            {ser_out, bit_clk_en, overrun}, 0);
      rst_n    = 1'b1;
      pos      = 0;
      fidx     = 0;
      hold_cnt = 0;
      exp_ovr  = 0;
      en_bad   = 0;
      got      = '0;
      while (fidx < NF) begin
         @(negedge clk);
         len = (ovc_mode && (fidx % 3 == 2)) ? 16 : 14;
         got[pos] = ser_out;
         if (bit_clk_en !== 1'b1) en_bad = 1;
         // stimulus for the next frame
         if (hold_cnt != 0) begin
            hold_cnt--;
            if (hold_cnt == 0) word_strobe = 1'b0;
         end
         if (pos == 3 && pd[fidx+1]) begin
            word_strobe = 1'b1; word_in = ~pw[fidx+1]; hold_cnt = 1;
         end
         if (pos == 6 && pv[fidx+1]) begin
            word_strobe = 1'b1; word_in = pw[fidx+1];
            hold_cnt = ph[fidx+1] ? 18 : 1;
            if (pd[fidx+1]) exp_ovr = 1;
         end
         if (pos == len - 1) begin
            exp = '0;
            if (pv[fidx]) begin
               exp[11:0] = pw[fidx];
               exp[12]   = 1'b1;
            end
            tag = ovc_mode ? "R3" : "R2";
            if (!pv[fidx])          tag = {tag, " R7"};
            else                    tag = {tag, " R4"};
            if (len == 16)          tag = {tag, " R5"};
            if (fidx > 0 && ph[fidx-1]) tag = {tag, " R6"};
            if (pd[fidx])           tag = {tag, " R8"};
            check(got == exp, $sformatf("%s frame %0d", tag, fidx), got, exp);
            check(!en_bad, $sformatf("R9 clock enable frame %0d", fidx), en_bad, 0);
            check(overrun == exp_ovr, $sformatf("R8 overrun flag frame %0d", fidx),
                  overrun, exp_ovr);
            got    = '0;
            en_bad = 0;
            pos    = 0;
            fidx++;
         end else begin
            pos++;
         end
      end
   endtask

   initial begin
      rst_n = 1'b0; overclock = 1'b0; word_strobe = 1'b0; word_in = '0;
      // standard cadence
      clear_plan();
      pv[1] = 1; pw[1] = 12'hA5A;
      pv[2] = 1; pw[2] = 12'h3C3;
      pv[4] = 1; pw[4] = 12'hFFF;
      pv[5] = 1; pw[5] = 12'h001; pd[5] = 1;
      pv[6] = 1; pw[6] = 12'h800; ph[6] = 1;
      pv[8] = 1; pw[8] = 12'h555;
      pv[9] = 1; pw[9] = 12'h000;
      run_phase(1'b0);
      // overclocked cadence; the reset check also shows the overrun flag cleared
      clear_plan();
      pv[1] = 1; pw[1] = 12'hFFF;
      pv[2] = 1; pw[2] = 12'hABC;
      pv[3] = 1; pw[3] = 12'h123;
      pv[5] = 1; pw[5] = 12'hFFF;
      pv[6] = 1; pw[6] = 12'h7E1; ph[6] = 1;
      pv[8] = 1; pw[8] = 12'h0F0; pd[8] = 1;
      pv[9] = 1; pw[9] = 12'h9A6;
      run_phase(1'b1);
      // reset after an overrun in overclocked mode
      run_phase_reset_only();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   task automatic run_phase_reset_only();
      rst_n = 1'b0;
      word_strobe = 1'b0;
      repeat (2) @(negedge clk);
      // R1: overrun and outputs cleared by reset
      check(overrun == 1'b0 && ser_out == 1'b0 && bit_clk_en == 1'b0, "R1 reset after overrun",
            {ser_out, bit_clk_en, overrun}, 0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule